// File: doc/BRIEF.md
# Configuration Frame Bit-Flip Injector

This block emulates single-event and multi-bit upsets in a configuration memory that is organised in frames, where a frame is the smallest unit that can be read or written. One request gives a frame address and up to `NPOS` bit positions. The block reads every word of that frame into a local buffer and inverts the requested bits as the words arrive. It then writes the whole buffer back and reads the frame a second time, comparing each returned word against the buffer.

When the sequence ends, the block gives a one-cycle completion pulse. With the pulse come a pass/fail flag and the frame address it worked on, so a campaign controller can log the result. A frame that does not really exist reads back differently from what was written, so it is reported as a failed injection. An error response or a stalled port also ends the operation with a failure, so the block cannot hang.

The configuration port is a plain word-level request/acknowledge interface. The command framing of a real port is not modelled. With a responder that acknowledges one cycle after each request, an injection takes `6*FRAME_WORDS` clock edges from acceptance to the completion pulse. That is 246 edges for the default 41-word frame.

Top module: `frame_flip_injector`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Frame and position inputs that change after acceptance have no effect on that injection.
- R2: After acceptance the block first reads words 0 to `FRAME_WORDS-1` of the frame in ascending order with `cfg_we` low. While it waits for `cfg_ack`, it holds `cfg_req`, `cfg_word` and `cfg_we` steady.
- R3: Bit position i is encoded as follows. The word index is `req_word_idx[i*WIDX_W +: WIDX_W]` and the bit index is `req_bit_idx[i*BIDX_W +: BIDX_W]`. The position is used only when `req_pos_vld[i]` is 1, and a word index of `FRAME_WORDS` or above is ignored.
- R4: Each used position toggles its bit once, so two positions naming the same bit leave that bit unchanged. Several distinct bits in one frame are all inverted in one operation.
- R5: After the read pass, all words of the buffer, including the inverted bits, are written back in ascending order with `cfg_we` high. The write pass begins only after the last read is acknowledged.
- R6: After the write pass, the frame is read again and compared word by word with the buffer. `done_ok` is 1 only if every word matches. For an address whose reads return all ones and whose writes are lost, a non-empty flip gives `done_ok`=0.
- R7: An acknowledge with `cfg_err`=1 ends the operation at once. The completion pulse follows on the next cycle with `done_ok`=0.
- R8: If `cfg_ack` stays low for `ACK_TIMEOUT` cycles while a request is outstanding, the operation ends with `done_ok`=0.
- R9: `done` is a one-cycle pulse with `done_ok` and `done_frame`, which equals the accepted address. With a responder that acknowledges one cycle after each request, `done` comes `6*FRAME_WORDS` edges after acceptance, and `req_ready` returns on the next cycle.
- R10: A request with no usable position writes the frame back unchanged and reports `done_ok`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Injection request valid |
| req_ready | output | 1 | Block idle and able to accept |
| req_frame | input | ADDR_W | Frame address to corrupt |
| req_pos_vld | input | NPOS | Per-position enable |
| req_word_idx | input | NPOS*WIDX_W | Packed word indices |
| req_bit_idx | input | NPOS*BIDX_W | Packed bit indices |
| cfg_req | output | 1 | Word access request to configuration port |
| cfg_we | output | 1 | 1 = write word, 0 = read word |
| cfg_frame | output | ADDR_W | Frame address of the access |
| cfg_word | output | WIDX_W | Word index of the access |
| cfg_wdata | output | WORD_W | Write data |
| cfg_ack | input | 1 | Access completed |
| cfg_rdata | input | WORD_W | Read data, valid with cfg_ack |
| cfg_err | input | 1 | Error response, valid with cfg_ack |
| done | output | 1 | Completion pulse |
| done_ok | output | 1 | Injection verified, valid with done |
| done_frame | output | ADDR_W | Address that was processed, valid with done |

## Verification
The bench targets several corner cases.
- Flips in word 0 and in the last word of the frame: a design with an off-by-one word pointer would corrupt the wrong word or miss the last one.
- Duplicate positions and a disabled position whose fields point at a real bit: a design that ORs rather than toggles, or ignores the enable, leaves a flipped bit where none belongs.
- Out-of-range word indices: a design that fails to filter them would alias them onto an existing word.
- An unmapped frame, an error response and a stalled port: the bench checks that each one gives a failure pulse at a predicted cycle, where a design that trusts the port would report a pass or never finish.

// File: rtl/frame_flip_injector.sv
module frame_flip_injector #(
  parameter int ADDR_W      = 16,
  parameter int WORD_W      = 32,
  parameter int FRAME_WORDS = 41,
  parameter int NPOS        = 4,
  parameter int ACK_TIMEOUT = 16,
  localparam int WIDX_W     = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1,
  localparam int BIDX_W     = (WORD_W > 1) ? $clog2(WORD_W) : 1,
  localparam int TW         = $clog2(ACK_TIMEOUT + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_frame,
  input  logic [NPOS-1:0]          req_pos_vld,
  input  logic [NPOS*WIDX_W-1:0]   req_word_idx,
  input  logic [NPOS*BIDX_W-1:0]   req_bit_idx,
  output logic                     cfg_req,
  output logic                     cfg_we,
  output logic [ADDR_W-1:0]        cfg_frame,
  output logic [WIDX_W-1:0]        cfg_word,
  output logic [WORD_W-1:0]        cfg_wdata,
  input  logic                     cfg_ack,
  input  logic [WORD_W-1:0]        cfg_rdata,
  input  logic                     cfg_err,
  output logic                     done,
  output logic                     done_ok,
  output logic [ADDR_W-1:0]        done_frame
);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_VF, S_DONE} st_t;

  st_t                      st;
  logic [NPOS-1:0]          pv_q;
  logic [NPOS*WIDX_W-1:0]   wi_q;
  logic [NPOS*BIDX_W-1:0]   bi_q;
  logic [ADDR_W-1:0]        frm_q;
  logic [WIDX_W-1:0]        wptr;
  logic [TW-1:0]            tmo;
  logic                     mism, fail_q;
  logic [WORD_W-1:0]        flip_mask;
  logic [WORD_W-1:0]        fbuf [FRAME_WORDS];

  wire last_w   = (wptr == WIDX_W'(FRAME_WORDS - 1));
  wire tmo_hit  = cfg_req && !cfg_ack && (tmo == TW'(ACK_TIMEOUT - 1));
  wire err_hit  = cfg_req && cfg_ack && cfg_err;
  wire cur_diff = (cfg_rdata != fbuf[wptr]);

  assign req_ready  = (st == S_IDLE);
  assign cfg_req    = (st == S_RD) || (st == S_WR) || (st == S_VF);
  assign cfg_we     = (st == S_WR);
  assign cfg_frame  = frm_q;
  assign cfg_word   = wptr;
  assign cfg_wdata  = fbuf[wptr];
  assign done       = (st == S_DONE);
  assign done_ok    = !fail_q;
  assign done_frame = frm_q;

  always_comb begin
    flip_mask = '0;
    for (int i = 0; i < NPOS; i++)
      if (pv_q[i] && (wi_q[i*WIDX_W +: WIDX_W] == wptr))
        flip_mask = flip_mask ^ (WORD_W'(1) << bi_q[i*BIDX_W +: BIDX_W]);
  end

  always_ff @(posedge clk)
    if (st == S_RD && cfg_ack && !cfg_err)
      fbuf[wptr] <= cfg_rdata ^ flip_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pv_q   <= '0;
      wi_q   <= '0;
      bi_q   <= '0;
      frm_q  <= '0;
      wptr   <= '0;
      tmo    <= '0;
      mism   <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          pv_q   <= req_pos_vld;
          wi_q   <= req_word_idx;
          bi_q   <= req_bit_idx;
          frm_q  <= req_frame;
          wptr   <= '0;
          tmo    <= '0;
          mism   <= 1'b0;
          fail_q <= 1'b0;
          st     <= S_RD;
        end
        S_RD, S_WR, S_VF: begin
          if (err_hit || tmo_hit) begin
            fail_q <= 1'b1;
            st     <= S_DONE;
          end else if (cfg_ack) begin
            tmo <= '0;
            if (st == S_VF && cur_diff) mism <= 1'b1;
            if (last_w) begin
              wptr <= '0;
              case (st)
                S_RD:    st <= S_WR;
                S_WR:    st <= S_VF;
                default: begin
                  st     <= S_DONE;
                  fail_q <= mism || cur_diff;
                end
              endcase
            end else begin
              wptr <= wptr + 1'b1;
            end
          end else begin
            tmo <= tmo + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ACCEPT_STARTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> cfg_req && !cfg_we && cfg_word == '0); // R2

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack && !tmo_hit |=> cfg_req && $stable(cfg_word) && $stable(cfg_we)); // R2

  AST_WRITE_AFTER_LAST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_we) |-> $past(cfg_ack) && $past(cfg_word) == WIDX_W'(FRAME_WORDS - 1)); // R5

  AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    err_hit |=> done && !done_ok); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready); // R9

endmodule

// File: tb/tb_frame_flip_injector.sv
module tb_frame_flip_injector;
  localparam int AW = 16, WW = 32, FW = 41, NP = 4, TMO = 16;
  localparam int WIW = $clog2(FW), BIW = $clog2(WW);
  localparam int NFR = 4;
  localparam logic [AW-1:0] F_UNMAP = 16'd9, F_ERR = 16'd10, F_STALL = 16'd11;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [AW-1:0] req_frame = '0;
  logic [NP-1:0] req_pos_vld = '0;
  logic [NP*WIW-1:0] req_word_idx = '0;
  logic [NP*BIW-1:0] req_bit_idx = '0;
  logic cfg_req, cfg_we, cfg_ack = 0, cfg_err = 0;
  logic [AW-1:0] cfg_frame;
  logic [WIW-1:0] cfg_word;
  logic [WW-1:0] cfg_wdata, cfg_rdata = '0;
  logic done, done_ok;
  logic [AW-1:0] done_frame;

  frame_flip_injector #(.ADDR_W(AW), .WORD_W(WW), .FRAME_WORDS(FW), .NPOS(NP), .ACK_TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_frame(req_frame),
    .req_pos_vld(req_pos_vld), .req_word_idx(req_word_idx), .req_bit_idx(req_bit_idx),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_frame(cfg_frame), .cfg_word(cfg_word), .cfg_wdata(cfg_wdata),
    .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .done(done), .done_ok(done_ok), .done_frame(done_frame));

  always #2 clk = ~clk;

  int errs = 0, checks = 0, wd = 0;
  int edge_n = 0, acc_edge = 0, exp_lat = 0;
  bit busy = 0, live = 0;
  logic [WW-1:0] mem [NFR][FW];
  logic [WW-1:0] expf [FW];
  int pw [NP];
  int pb [NP];

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // configuration memory model: ack one cycle after request
  always @(posedge clk) begin
    edge_n <= edge_n + 1;
    if (req_valid && req_ready) begin
      busy <= 1; acc_edge <= edge_n + 1;
    end else if (busy && edge_n + 1 > acc_edge + exp_lat) busy <= 0;
    if (cfg_ack) begin
      cfg_ack <= 0; cfg_err <= 0;
    end else if (cfg_req && cfg_frame != F_STALL) begin
      cfg_ack <= 1;
      cfg_err <= (cfg_frame == F_ERR);
      if (cfg_frame < NFR) begin
        if (cfg_we) mem[cfg_frame][cfg_word] <= cfg_wdata;
        else cfg_rdata <= mem[cfg_frame][cfg_word];
      end else cfg_rdata <= '1;
    end
  end

  // per-cycle reference of ready and done timing (R1, R9)
  always @(negedge clk) if (live) begin
    chk(done == (busy && edge_n == acc_edge + exp_lat), "R9", "done timing", done, busy && edge_n == acc_edge + exp_lat);
    chk(req_ready == !(busy && edge_n <= acc_edge + exp_lat), "R1", "ready", req_ready, !(busy && edge_n <= acc_edge + exp_lat));
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected<%0d", wd, 150000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic run(input logic [AW-1:0] f, input logic [NP-1:0] pv, input int lat, input bit exp_ok, input string req);
    if (f < NFR) begin
      for (int w = 0; w < FW; w++) expf[w] = mem[f][w];
      for (int i = 0; i < NP; i++)
        if (pv[i] && pw[i] < FW) expf[pw[i]][pb[i]] = ~expf[pw[i]][pb[i]];
    end
    @(negedge clk);
    exp_lat = lat;
    req_frame = f; req_pos_vld = pv;
    for (int i = 0; i < NP; i++) begin
      req_word_idx[i*WIW +: WIW] = WIW'(pw[i]);
      req_bit_idx[i*BIW +: BIW] = BIW'(pb[i]);
    end
    req_valid = 1;
    @(posedge clk); #1;
    req_valid = 0;
    req_frame = '1; req_pos_vld = '1; req_word_idx = '0; req_bit_idx = '0;  // R1: changes after acceptance
    do @(negedge clk); while (!done);
    chk(done_ok == exp_ok, req, "done_ok", done_ok, exp_ok);
    chk(done_frame == f, "R9", "done_frame", done_frame, f);
    if (f < NFR)
      for (int w = 0; w < FW; w++)
        if (mem[f][w] != expf[w]) chk(0, req, $sformatf("frame %0d word %0d", f, w), mem[f][w], expf[w]);
    if (f < NFR) chk(1, req, "frame content", 0, 0);
    @(negedge clk);
  endtask

  initial begin
    for (int f = 0; f < NFR; f++)
      for (int w = 0; w < FW; w++) mem[f][w] = 32'h5A3C0000 ^ (f << 12) ^ (w * 32'h01030507);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && done == 0 && cfg_req == 0, "R1", "reset state", {req_ready, done, cfg_req}, 3'b100);
    live = 1;
    // R3 single bit in word 0
    pw = '{0, 0, 0, 0}; pb = '{0, 0, 0, 0};
    run(16'd1, 4'b0001, 6*FW, 1, "R3");
    // R4 multi-bit, last word and adjacent bits; R5 write back
    pw = '{40, 20, 20, 3}; pb = '{31, 7, 8, 15};
    run(16'd2, 4'b1111, 6*FW, 1, "R4");
    // R4 duplicate cancels; R3 disabled position ignored
    pw = '{5, 5, 5, 6}; pb = '{9, 9, 10, 1};
    run(16'd3, 4'b0111, 6*FW, 1, "R4");
    // R3 out-of-range word indices ignored; R10 frame unchanged
    pw = '{41, 63, 50, 44}; pb = '{0, 31, 3, 4};
    run(16'd0, 4'b1111, 6*FW, 1, "R10");
    // R10 no valid positions
    pw = '{2, 3, 4, 5}; pb = '{1, 1, 1, 1};
    run(16'd0, 4'b0000, 6*FW, 1, "R10");
    // R6 unmapped frame fails verification
    pw = '{7, 0, 0, 0}; pb = '{3, 0, 0, 0};
    run(F_UNMAP, 4'b0001, 6*FW, 0, "R6");
    // R7 error response aborts after first acknowledge
    run(F_ERR, 4'b0001, 2, 0, "R7");
    // R8 stalled port times out
    run(F_STALL, 4'b0001, TMO, 0, "R8");
    // R2 back-to-back: undo first flip, restoring frame 1
    pw = '{0, 0, 0, 0}; pb = '{0, 0, 0, 0};
    run(16'd1, 4'b0001, 6*FW, 1, "R2");
    live = 0;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule